// File: doc/BRIEF.md
# IO Rail Deep Power-Down Controller

This block is a small register-mapped controller that parks IO rails in a deep power-down state and brings them back out. It handles up to sixty rails, split into two banks of thirty. Software writes a request word. The word carries a 2-bit command in its top bits and a rail-select mask in the lower thirty bits. The controller then waits a programmable number of peripheral clock cycles before it commits the change. This settle delay gives the pads their minimum power-down sampling window. After the delay the per-rail status bits and the per-rail power-down output lines change together.

Commands are taken only while a sampling-enable bit is set. Only one command can be in flight at a time. While a command is being timed, further request writes are dropped, and the command field of the active bank reads back the pending command so software can poll for completion. Rails outside the select mask are never touched.

Top module: `rail_sleep_ctrl`

## Requirements
- R1: After reset every `railDown` line is 0. Both status registers (0x1BC, 0x1C4), both request registers (0x1B8, 0x1C0), the sample register (0x020) and the settle register (0x1C8) read 0.
- R2: Rail `b` of bank 0 is bit `b` (0..29) of registers 0x1B8 and 0x1BC and drives `railDown[b]`. Rail `b` of bank 1 is bit `b` of 0x1C0 and 0x1C4 and drives `railDown[30+b]`. Bits 29:0 of a request register read back the select mask of the last accepted command on that bank.
- R3: Command value 2 in request bits 31:30 puts every selected rail into deep power-down: its status bit and its `railDown` line become 1.
- R4: Command value 1 brings every selected rail out of deep power-down: its status bit and its `railDown` line become 0.
- R5: A request write is ignored unless bit 0 of register 0x020 is 1 at the time of the write.
- R6: When a command is accepted on clock edge E, status and `railDown` change exactly at edge E+N and not before. N is the value of register 0x1C8 (16 bits), and a value of 0 is treated as N=1.
- R7: A request write with command value 0 or 3 changes no rail state and no select readback.
- R8: From acceptance until completion, bits 31:30 of the active bank's request register read the pending command. Those bits read 0 afterwards. Any request write that lands while a command is pending, including one on the completion edge itself, is dropped.
- R9: Rails that are not selected keep their state through a command. Bits 31:30 of the status registers always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 12 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the cycle `rdEn` is high, 0 otherwise |
| railDown | output | 60 | Per-rail deep power-down line, 1 = rail in deep power-down |

## Verification
Two events can fall in the same cycle: a pending command reaching the end of its settle count, and a fresh request write. The bench programs a settle count of three, issues a command on bank 0, and times a write to bank 1 so that it lands on the exact completion edge. It then checks two things: the bank 0 rails switched on that edge, and the bank 1 rails and bank 1 select readback stayed unchanged. Randomised commands with settle counts that include zero also check, every cycle, that status holds its old value until the final cycle of the count.

// File: rtl/rail_sleep_pkg.sv
package rail_sleep_pkg;
  localparam int BANK_RAILS = 30;
  localparam int NUM_BANKS  = 2;
  localparam int NUM_RAILS  = BANK_RAILS * NUM_BANKS;
  localparam int ADDR_W     = 12;

  localparam logic [ADDR_W-1:0] OFF_SAMPLE = 12'h020;
  localparam logic [ADDR_W-1:0] OFF_REQ0   = 12'h1B8;
  localparam logic [ADDR_W-1:0] OFF_STAT0  = 12'h1BC;
  localparam logic [ADDR_W-1:0] OFF_REQ1   = 12'h1C0;
  localparam logic [ADDR_W-1:0] OFF_STAT1  = 12'h1C4;
  localparam logic [ADDR_W-1:0] OFF_SETTLE = 12'h1C8;

  typedef enum logic [1:0] {
    CMD_IDLE  = 2'd0,
    CMD_WAKE  = 2'd1,
    CMD_SLEEP = 2'd2,
    CMD_RSVD  = 2'd3
  } railCmd_e;

  typedef struct packed {
    logic accept;   // start a command this cycle
    logic apply;    // commit pending command this cycle
    logic bank;     // bank of the pending command
    logic goDown;   // pending command enters power-down
  } ctlStrobe_t;
endpackage

// File: rtl/rail_sleep_ctl.sv
module rail_sleep_ctl
  import rail_sleep_pkg::*;
#(
  parameter int TIMER_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqWr,
  input  logic               reqBank,
  input  railCmd_e           reqCmd,
  input  logic               sampleEn,
  input  logic [TIMER_W-1:0] settleCnt,
  output ctlStrobe_t         ctl,
  output logic               busy,
  output railCmd_e           pendCmd
);
  localparam logic [TIMER_W-1:0] ONE = TIMER_W'(1);

  logic [TIMER_W-1:0] remain;
  logic               pendBank;
  logic               cmdValid;
  logic [TIMER_W-1:0] loadVal;

  assign cmdValid = (reqCmd == CMD_WAKE) || (reqCmd == CMD_SLEEP);
  assign loadVal  = (settleCnt == '0) ? ONE : settleCnt;

  always_comb begin
    ctl.accept = reqWr && !busy && sampleEn && cmdValid;
    ctl.apply  = busy && (remain == ONE);
    ctl.bank   = pendBank;
    ctl.goDown = (pendCmd == CMD_SLEEP);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      remain   <= '0;
      pendBank <= 1'b0;
      pendCmd  <= CMD_IDLE;
    end else if (ctl.accept) begin
      busy     <= 1'b1;
      remain   <= loadVal;
      pendBank <= reqBank;
      pendCmd  <= reqCmd;
    end else if (ctl.apply) begin
      busy    <= 1'b0;
      pendCmd <= CMD_IDLE;
    end else if (busy) begin
      remain <= remain - ONE;
    end
  end

  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rstN)
    busy && !ctl.apply && reqWr |=> busy && $stable(pendCmd) && $stable(pendBank)); // R8
  AST_BUSY_SHOWS_CMD: assert property (@(posedge clk) disable iff (!rstN)
    ctl.accept |=> busy && (pendCmd != CMD_IDLE)); // R8
  AST_SAMPLE_GATE: assert property (@(posedge clk) disable iff (!rstN)
    !busy && !sampleEn |=> !busy); // R5
  AST_RSVD_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    !busy && reqWr && (reqCmd == CMD_RSVD || reqCmd == CMD_IDLE) |=> !busy); // R7
endmodule

// File: rtl/rail_sleep_dp.sv
module rail_sleep_dp
  import rail_sleep_pkg::*;
#(
  parameter int TIMER_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic                 rdEn,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [31:0]          wdata,
  input  ctlStrobe_t           ctl,
  input  logic                 busy,
  input  railCmd_e             pendCmd,
  output logic [31:0]          rdata,
  output logic [NUM_RAILS-1:0] railDown,
  output logic                 sampleEn,
  output logic [TIMER_W-1:0]   settleCnt,
  output logic                 reqWr,
  output logic                 reqBank,
  output railCmd_e             reqCmd
);
  logic [BANK_RAILS-1:0] selLatch [NUM_BANKS];
  logic [BANK_RAILS-1:0] pendSel;
  logic [NUM_RAILS-1:0]  railState;
  logic [NUM_RAILS-1:0]  applyMask;

  assign reqWr   = wrEn && ((addr == OFF_REQ0) || (addr == OFF_REQ1));
  assign reqBank = (addr == OFF_REQ1);
  assign reqCmd  = railCmd_e'(wdata[31:30]);
  assign railDown = railState;

  always_comb begin
    applyMask = '0;
    applyMask[ctl.bank*BANK_RAILS +: BANK_RAILS] = pendSel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampleEn  <= 1'b0;
      settleCnt <= '0;
    end else if (wrEn) begin
      if (addr == OFF_SAMPLE) sampleEn  <= wdata[0];
      if (addr == OFF_SETTLE) settleCnt <= wdata[TIMER_W-1:0];
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                       selLatch[b] <= '0;
      else if (ctl.accept && (reqBank == b[0]))        selLatch[b] <= wdata[BANK_RAILS-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendSel   <= '0;
      railState <= '0;
    end else begin
      if (ctl.accept) pendSel <= wdata[BANK_RAILS-1:0];
      if (ctl.apply)
        railState <= ctl.goDown ? (railState | applyMask) : (railState & ~applyMask);
    end
  end

  always_comb begin
    rdata = '0;
    if (rdEn) begin
      unique case (addr)
        OFF_SAMPLE: rdata = {31'b0, sampleEn};
        OFF_SETTLE: rdata = 32'(settleCnt);
        OFF_REQ0:   rdata = {(busy && !ctl.bank) ? pendCmd : CMD_IDLE, selLatch[0]};
        OFF_REQ1:   rdata = {(busy && ctl.bank) ? pendCmd : CMD_IDLE, selLatch[1]};
        OFF_STAT0:  rdata = {2'b0, railState[BANK_RAILS-1:0]};
        OFF_STAT1:  rdata = {2'b0, railState[NUM_RAILS-1:BANK_RAILS]};
        default:    rdata = '0;
      endcase
    end
  end

  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.apply |=> $stable(railState)); // R6
  AST_UNSEL_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    ctl.apply |=> ((railState ^ $past(railState)) & ~$past(applyMask)) == '0); // R9
  AST_DOWN_SET: assert property (@(posedge clk) disable iff (!rstN)
    ctl.apply && ctl.goDown |=> (railState & $past(applyMask)) == $past(applyMask)); // R3
  AST_UP_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    ctl.apply && !ctl.goDown |=> (railState & $past(applyMask)) == '0); // R4
endmodule

// File: rtl/rail_sleep_ctrl.sv
module rail_sleep_ctrl
  import rail_sleep_pkg::*;
#(
  parameter int TIMER_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic                 rdEn,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [31:0]          wdata,
  output logic [31:0]          rdata,
  output logic [NUM_RAILS-1:0] railDown
);
  ctlStrobe_t         ctl;
  logic               busy;
  railCmd_e           pendCmd;
  logic               sampleEn;
  logic [TIMER_W-1:0] settleCnt;
  logic               reqWr;
  logic               reqBank;
  railCmd_e           reqCmd;

  rail_sleep_ctl #(.TIMER_W(TIMER_W)) u_ctl (
    .clk(clk), .rstN(rstN), .reqWr(reqWr), .reqBank(reqBank), .reqCmd(reqCmd),
    .sampleEn(sampleEn), .settleCnt(settleCnt), .ctl(ctl), .busy(busy), .pendCmd(pendCmd)
  );

  rail_sleep_dp #(.TIMER_W(TIMER_W)) u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wdata(wdata),
    .ctl(ctl), .busy(busy), .pendCmd(pendCmd), .rdata(rdata), .railDown(railDown),
    .sampleEn(sampleEn), .settleCnt(settleCnt), .reqWr(reqWr), .reqBank(reqBank),
    .reqCmd(reqCmd)
  );
endmodule

// File: tb/tb_rail_sleep_ctrl.sv
`timescale 1ns/1ps
module tb_rail_sleep_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [59:0] railDown;

  int checks = 0;
  int failures = 0;

  logic [59:0] expState = '0;
  logic [29:0] expSel [2];
  logic        sampleOn = 1'b0;
  int          settle = 0;

  rail_sleep_ctrl dut (.clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
                       .wdata(wdata), .rdata(rdata), .railDown(railDown));

  always #5 clk = ~clk;

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  function automatic logic [11:0] reqAddr(input int bank);
    return bank == 0 ? 12'h1B8 : 12'h1C0;
  endfunction

  function automatic int effN(input int t);
    return t == 0 ? 1 : t;
  endfunction

  function automatic logic [59:0] applyCmd(input logic [59:0] s, input int bank,
                                           input logic [1:0] cmd, input logic [29:0] sel);
    logic [59:0] m;
    m = bank == 0 ? {30'b0, sel} : {sel, 30'b0};
    return cmd == 2'd2 ? (s | m) : (s & ~m);
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1;
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    rdEn = 1'b1; addr = a;
    #1;
    v = rdata;
    rdEn = 1'b0;
  endtask

  task automatic chkState(input string req);
    logic [31:0] v;
    rd(12'h1BC, v); check({req, " stat0"}, 64'(v), 64'({2'b0, expState[29:0]}));
    rd(12'h1C4, v); check({req, " stat1"}, 64'(v), 64'({2'b0, expState[59:30]}));
    check({req, " railDown"}, 64'(railDown), 64'(expState));
  endtask

  task automatic doCmd(input int bank, input logic [1:0] cmd, input logic [29:0] sel);
    logic [31:0] v;
    logic [59:0] oldS;
    logic [59:0] newS;
    bit acc;
    int n;
    wr(reqAddr(bank), {cmd, sel});
    acc = sampleOn && (cmd == 2'd1 || cmd == 2'd2);
    if (acc) begin
      n = effN(settle);
      rd(reqAddr(bank), v);
      check("R8 pending cmd field", 64'(v[31:30]), 64'(cmd));
      oldS = expState;
      newS = applyCmd(expState, bank, cmd, sel);
      for (int c = 1; c <= n; c++) begin
        @(posedge clk); #2;
        expState = (c < n) ? oldS : newS;
        if (c < n) chkState("R6 settle hold");
        else if (cmd == 2'd2) chkState("R3 R9 R6 sleep");
        else chkState("R4 R9 R6 wake");
      end
      expSel[bank] = sel;
      rd(reqAddr(bank), v);
      check("R8 done field", 64'(v[31:30]), 64'd0);
      check("R2 select readback", 64'(v[29:0]), 64'(sel));
    end else begin
      repeat (3) @(posedge clk);
      #2;
      chkState(sampleOn ? "R7 ignored cmd" : "R5 sampling off");
      rd(reqAddr(bank), v);
      check(sampleOn ? "R7 select kept" : "R5 select kept", 64'(v), 64'({2'b0, expSel[bank]}));
    end
  endtask

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    expSel[0] = '0; expSel[1] = '0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    chkState("R1 reset");
    rd(12'h1B8, v); check("R1 req0", 64'(v), 64'd0);
    rd(12'h1C0, v); check("R1 req1", 64'(v), 64'd0);
    rd(12'h020, v); check("R1 sample", 64'(v), 64'd0);
    rd(12'h1C8, v); check("R1 settle", 64'(v), 64'd0);

    settle = 2; wr(12'h1C8, 32'd2);
    doCmd(0, 2'd2, 30'h3FFF_FFFF);          // R5: sampling disabled
    sampleOn = 1'b1; wr(12'h020, 32'd1);
    settle = 0; wr(12'h1C8, 32'd0);
    doCmd(1, 2'd2, 30'h0000_0001);          // R6: zero count acts as one, R2 bank1 bit0
    check("R2 rail 30 line", 64'(railDown[30]), 64'd1);
    doCmd(1, 2'd3, 30'h0000_0001);          // R7 reserved
    doCmd(0, 2'd0, 30'h2AAA_AAAA);          // R7 idle
    settle = 5; wr(12'h1C8, 32'd5);
    doCmd(0, 2'd2, 30'h2AAA_AAAA);
    doCmd(0, 2'd1, 30'h0000_FFFF);

    // R8: request on the completion edge is dropped
    settle = 3; wr(12'h1C8, 32'd3);
    wr(12'h1B8, {2'd2, 30'h0000_0F00});
    @(posedge clk); #2;
    @(posedge clk); #2;
    wr(12'h1C0, {2'd2, 30'h3FFF_FFFF});
    #1;
    expState = applyCmd(expState, 0, 2'd2, 30'h0000_0F00);
    expSel[0] = 30'h0000_0F00;
    chkState("R8 collision");
    rd(12'h1C0, v); check("R8 collision select", 64'(v), 64'({2'b0, expSel[1]}));
    repeat (4) @(posedge clk); #2;
    chkState("R8 collision late");

    for (int i = 0; i < 40; i++) begin
      int t;
      if (($urandom % 8) == 0) begin
        sampleOn = ~sampleOn; wr(12'h020, {31'b0, sampleOn});
      end
      t = $urandom % 5;
      settle = t; wr(12'h1C8, 32'(t));
      doCmd($urandom % 2, 2'($urandom % 4), 30'($urandom));
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule